// File: doc/BRIEF.md
# SCSI Interrupt and Status Unit

This block gathers the event pulses of a SCSI bus controller into latched status flags and a single interrupt request line. It sits on a small host register bus with a 3-bit address, one-cycle read and write strobes and 8-bit data. Two addresses are special. A read of address 7 returns the status byte and clears every latched flag. Writes to addresses 5, 6 and 7 are command strobes that start a DMA transfer, and the write data is never looked at.

A four-state transfer machine tracks whether a DMA transfer is running. The states are `XFER_IDLE`, `XFER_SEND`, `XFER_TGT_RX` and `XFER_INI_RX`. The machine makes these transitions:

- *launch*: from idle to the state matching an accepted start write.
- *finish*: from an active state to idle on an end-of-process event.
- *abort-reset*: from an active state to idle on a SCSI bus reset event.
- *abort-mode*: from an active state to idle when the DMA mode bit drops.
- *hold*: otherwise the state stays where it is.

An end-of-process pulse counts as an event only while a transfer is active. Every source latches its own flag whether or not it is enabled. The interrupt flag is set only by sources whose enable bit is 1.

Top module: `scsi_irq_status`

## Requirements
- R1: After reset, `irq` and all three start outputs are 0, and the status byte reads 0x00.
- R2: A write to address 5 while idle with mode bit 1 = 1 gives a one-cycle `start_send` pulse in the cycle after the write, whatever the write data. The state becomes `XFER_SEND`.
- R3: A write to address 6 while idle with mode bit 1 = 1 and mode bit 6 = 1 gives a one-cycle `start_tgt_rx` pulse in the next cycle. The state becomes `XFER_TGT_RX`.
- R4: A write to address 7 while idle with mode bit 1 = 1 and mode bit 6 = 0 gives a one-cycle `start_ini_rx` pulse in the next cycle. The state becomes `XFER_INI_RX`.
- R5: A start write is rejected if its mode bits are wrong or a transfer is already active. A rejected write gives no pulse and changes no flag or state.
- R6: An active transfer returns to idle after an end-of-process event, a bus reset event, or a cycle with mode bit 1 = 0. Status bit 0 reads 1 exactly while a transfer is active.
- R7: Each event pulse sets its status bit from the next cycle on. The bits are: selection = bit 6, end-of-process = bit 7 (only while active), parity error = bit 5, phase mismatch = bit 3, disconnection (busy error) = bit 2, bus reset = bit 1.
- R8: The interrupt flag (status bit 4) and `irq` rise in the cycle after an event whose enable bit is 1. The enable bits are: src_en[0] selection, [1] end-of-process, [2] bus reset, [3] parity, [4] phase, [5] disconnection. An event whose enable bit is 0 sets its flag but not `irq`.
- R9: A read of address 7 clears status bits 7 to 1, including bits 5, 4 and 2, and drops `irq` from the next cycle on. A read of address 5 clears nothing.
- R10: An event arriving in the same cycle as a clearing read leaves its flag set.
- R11: During a read strobe, `bus_rdata` shows the status byte for addresses 5 and 7. It is 0 for any other address and whenever no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data (ignored by all decoded writes) |
| bus_rdata | output | 8 | Read data |
| mode_bits | input | 8 | Mode register bits (bit 1 DMA mode, bit 6 target mode) |
| src_en | input | 6 | Per-source interrupt enables |
| ev_select | input | 1 | Selection or reselection event |
| ev_eop | input | 1 | End-of-process event |
| ev_bus_reset | input | 1 | SCSI bus reset event |
| ev_parity | input | 1 | Parity error event |
| ev_phase_mm | input | 1 | Bus phase mismatch event |
| ev_disconnect | input | 1 | Bus disconnection event |
| irq | output | 1 | Interrupt request |
| start_send | output | 1 | DMA send start pulse |
| start_tgt_rx | output | 1 | DMA target receive start pulse |
| start_ini_rx | output | 1 | DMA initiator receive start pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit data bus, a 3-bit address, the start strobes at addresses 5, 6 and 7, and the DMA and target bits at mode positions 1 and 6. These values make every decoded address reachable. That includes address 7, where a clearing read and an initiator start share one decode, so the read side and the write side of that address are both exercised. Directed sequences visit every state transition, including starts rejected while a transfer is active. A random phase then mixes reads, writes, mode changes and events that coincide with clearing reads.

// File: rtl/scsi_evt_pkg.sv
package scsi_evt_pkg;

    typedef enum logic [1:0] {
        XFER_IDLE   = 2'd0,
        XFER_SEND   = 2'd1,
        XFER_TGT_RX = 2'd2,
        XFER_INI_RX = 2'd3
    } xfer_state_e;

    // event source indices (also the src_en bit order)
    localparam int SRC_SEL   = 0;
    localparam int SRC_EOP   = 1;
    localparam int SRC_BRST  = 2;
    localparam int SRC_PAR   = 3;
    localparam int SRC_PHASE = 4;
    localparam int SRC_DISC  = 5;
    localparam int NUM_SRC   = 6;

    // status byte positions
    localparam int ST_ACTIVE = 0;
    localparam int ST_BRST   = 1;
    localparam int ST_BUSY   = 2;
    localparam int ST_PHASE  = 3;
    localparam int ST_IRQ    = 4;
    localparam int ST_PARITY = 5;
    localparam int ST_SEL    = 6;
    localparam int ST_EOP    = 7;

endpackage

// File: rtl/scsi_start_decode.sv
module scsi_start_decode #(
    parameter int ADDR_W       = 3,
    parameter int MODE_W       = 8,
    parameter int ADDR_SEND    = 5,
    parameter int ADDR_TGT     = 6,
    parameter int ADDR_INI     = 7,
    parameter int MODE_DMA_BIT = 1,
    parameter int MODE_TGT_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [MODE_W-1:0] mode,
    input  logic              idle,
    output logic              go_send,
    output logic              go_tgt,
    output logic              go_ini,
    output logic              start_send,
    output logic              start_tgt,
    output logic              start_ini
);
    localparam logic [ADDR_W-1:0] A_SEND = ADDR_W'(ADDR_SEND);
    localparam logic [ADDR_W-1:0] A_TGT  = ADDR_W'(ADDR_TGT);
    localparam logic [ADDR_W-1:0] A_INI  = ADDR_W'(ADDR_INI);

    logic dma_on;
    logic tgt_on;

    assign dma_on = mode[MODE_DMA_BIT];
    assign tgt_on = mode[MODE_TGT_BIT];

    always_comb begin
        go_send = wr && idle && dma_on && (addr == A_SEND);
        go_tgt  = wr && idle && dma_on && tgt_on && (addr == A_TGT);
        go_ini  = wr && idle && dma_on && !tgt_on && (addr == A_INI);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_send <= 1'b0;
            start_tgt  <= 1'b0;
            start_ini  <= 1'b0;
        end else begin
            start_send <= go_send;
            start_tgt  <= go_tgt;
            start_ini  <= go_ini;
        end
    end

    assert_tgt_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_tgt |-> ($past(mode[MODE_TGT_BIT]) && $past(mode[MODE_DMA_BIT])));
    assert_ini_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_ini |-> ($past(!mode[MODE_TGT_BIT]) && $past(mode[MODE_DMA_BIT])));
    assert_busy_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> !(go_send || go_tgt || go_ini));

endmodule

// File: rtl/scsi_xfer_fsm.sv
module scsi_xfer_fsm
    import scsi_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_send,
    input  logic        go_tgt,
    input  logic        go_ini,
    input  logic        dma_mode,
    input  logic        ev_eop,
    input  logic        ev_bus_reset,
    output xfer_state_e state,
    output logic        active
);
    xfer_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= XFER_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            XFER_IDLE: begin
                if (go_send)     state_nx = XFER_SEND;
                else if (go_tgt) state_nx = XFER_TGT_RX;
                else if (go_ini) state_nx = XFER_INI_RX;
            end
            XFER_SEND, XFER_TGT_RX, XFER_INI_RX: begin
                if (ev_eop || ev_bus_reset || !dma_mode) state_nx = XFER_IDLE;
            end
            default: state_nx = XFER_IDLE;
        endcase
    end

    assign active = (state != XFER_IDLE);

    assert_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (ev_bus_reset || !dma_mode)) |=> (state == XFER_IDLE));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !ev_eop && !ev_bus_reset && dma_mode) |=> $stable(state));

endmodule

// File: rtl/scsi_flag_latch.sv
module scsi_flag_latch #(
    parameter int N_SRC = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] ev,
    input  logic [N_SRC-1:0] en,
    input  logic             clr,
    output logic [N_SRC-1:0] flags,
    output logic             irq_flag
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= (flags[i] && !clr) || ev[i];
        end

        assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> flags[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_flag <= 1'b0;
        else        irq_flag <= (irq_flag && !clr) || (|(ev & en));
    end

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(|(ev & en)));
    assert_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_flag && ((ev & en) == '0)) |=> !irq_flag);
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (ev == '0)) |=> ((flags == '0) && !irq_flag));

endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
    import scsi_evt_pkg::*;
#(
    parameter int ADDR_W       = 3,
    parameter int DATA_W       = 8,
    parameter int ADDR_STATUS  = 5,
    parameter int ADDR_SEND    = 5,
    parameter int ADDR_TGT     = 6,
    parameter int ADDR_INI     = 7,
    parameter int ADDR_CLEAR   = 7,
    parameter int MODE_DMA_BIT = 1,
    parameter int MODE_TGT_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] mode_bits,
    input  logic [5:0]        src_en,
    input  logic              ev_select,
    input  logic              ev_eop,
    input  logic              ev_bus_reset,
    input  logic              ev_parity,
    input  logic              ev_phase_mm,
    input  logic              ev_disconnect,
    output logic              irq,
    output logic              start_send,
    output logic              start_tgt_rx,
    output logic              start_ini_rx
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(ADDR_CLEAR);

    logic              wdata_unused;
    logic              go_send, go_tgt, go_ini;
    logic              active;
    xfer_state_e       state;
    logic [NUM_SRC-1:0] ev_vec;
    logic [NUM_SRC-1:0] flags;
    logic              irq_flag;
    logic              clr;
    logic [DATA_W-1:0] status;

    assign wdata_unused = ^bus_wdata;

    scsi_start_decode #(
        .ADDR_W(ADDR_W), .MODE_W(DATA_W),
        .ADDR_SEND(ADDR_SEND), .ADDR_TGT(ADDR_TGT), .ADDR_INI(ADDR_INI),
        .MODE_DMA_BIT(MODE_DMA_BIT), .MODE_TGT_BIT(MODE_TGT_BIT)
    ) u_decode (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
        .mode(mode_bits), .idle(!active),
        .go_send(go_send), .go_tgt(go_tgt), .go_ini(go_ini),
        .start_send(start_send), .start_tgt(start_tgt_rx), .start_ini(start_ini_rx)
    );

    scsi_xfer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .go_send(go_send), .go_tgt(go_tgt), .go_ini(go_ini),
        .dma_mode(mode_bits[MODE_DMA_BIT]),
        .ev_eop(ev_eop), .ev_bus_reset(ev_bus_reset),
        .state(state), .active(active)
    );

    always_comb begin
        ev_vec            = '0;
        ev_vec[SRC_SEL]   = ev_select;
        ev_vec[SRC_EOP]   = ev_eop && active;
        ev_vec[SRC_BRST]  = ev_bus_reset;
        ev_vec[SRC_PAR]   = ev_parity;
        ev_vec[SRC_PHASE] = ev_phase_mm;
        ev_vec[SRC_DISC]  = ev_disconnect;
    end

    assign clr = bus_rd && (bus_addr == A_CLEAR);

    scsi_flag_latch #(.N_SRC(NUM_SRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .ev(ev_vec), .en(src_en), .clr(clr),
        .flags(flags), .irq_flag(irq_flag)
    );

    always_comb begin
        status            = '0;
        status[ST_ACTIVE] = active;
        status[ST_BRST]   = flags[SRC_BRST];
        status[ST_BUSY]   = flags[SRC_DISC];
        status[ST_PHASE]  = flags[SRC_PHASE];
        status[ST_IRQ]    = irq_flag;
        status[ST_PARITY] = flags[SRC_PAR];
        status[ST_SEL]    = flags[SRC_SEL];
        status[ST_EOP]    = flags[SRC_EOP];
    end

    assign bus_rdata = (bus_rd && ((bus_addr == A_STATUS) || (bus_addr == A_CLEAR)))
                       ? status : '0;
    assign irq = irq_flag;

    assert_one_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_send, start_tgt_rx, start_ini_rx}));
    assert_send_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_send |-> $past(bus_wr && (bus_addr == ADDR_W'(ADDR_SEND)) && mode_bits[MODE_DMA_BIT]));
    assert_pulse_short_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_send |=> !start_send);
    assert_active_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_send || start_tgt_rx || start_ini_rx) |-> active);
    assert_quiet_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));

endmodule

// File: tb/scsi_irq_status_bench.sv
`timescale 1ns/1ps
module scsi_irq_status_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0, mode_bits = '0;
    logic [7:0] bus_rdata;
    logic [5:0] src_en = '0;
    logic       ev_select = 0, ev_eop = 0, ev_bus_reset = 0, ev_parity = 0,
                ev_phase_mm = 0, ev_disconnect = 0;
    logic       irq, start_send, start_tgt_rx, start_ini_rx;

    always #4 clk = ~clk;

    scsi_irq_status u_scsi_irq_status (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_bits(mode_bits), .src_en(src_en),
        .ev_select(ev_select), .ev_eop(ev_eop), .ev_bus_reset(ev_bus_reset),
        .ev_parity(ev_parity), .ev_phase_mm(ev_phase_mm), .ev_disconnect(ev_disconnect),
        .irq(irq), .start_send(start_send), .start_tgt_rx(start_tgt_rx),
        .start_ini_rx(start_ini_rx)
    );

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // behavioural model state
    int m_state = 0;          // 0 idle, 1 send, 2 target rx, 3 initiator rx
    bit m_sel, m_eop, m_brst, m_par, m_phase, m_disc, m_irq;
    bit [2:0] m_pulse;        // {send, tgt, ini}

    localparam logic [7:0] M_NONE = 8'h00, M_DMA = 8'h02, M_TGT = 8'h42;

    function automatic logic [7:0] m_status();
        return {m_eop, m_sel, m_par, m_irq, m_phase, m_disc, m_brst, (m_state != 0)};
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_step(input logic [2:0] a, input bit rd, input bit wr,
                              input logic [7:0] md, input logic [5:0] en, input logic [5:0] ev);
        bit act = (m_state != 0);
        bit clr = rd && (a == 3'd7);
        bit dma = md[1], tgt = md[6];
        bit gs = wr && !act && dma && a == 3'd5;
        bit gt = wr && !act && dma && tgt && a == 3'd6;
        bit gi = wr && !act && dma && !tgt && a == 3'd7;
        logic [5:0] q = ev;
        q[1] = ev[1] && act;
        m_irq   = (m_irq && !clr) || ((q & en) != 0);
        m_sel   = (m_sel && !clr) || q[0];
        m_eop   = (m_eop && !clr) || q[1];
        m_brst  = (m_brst && !clr) || q[2];
        m_par   = (m_par && !clr) || q[3];
        m_phase = (m_phase && !clr) || q[4];
        m_disc  = (m_disc && !clr) || q[5];
        if (act) begin
            if (ev[1] || ev[2] || !dma) m_state = 0;
        end else if (gs) m_state = 1;
        else if (gt) m_state = 2;
        else if (gi) m_state = 3;
        m_pulse = {gs, gt, gi};
    endtask

    // one clock: drive at negedge, check read data, then outputs after the edge
    task automatic apply(input string tag, input logic [2:0] a, input bit rd, input bit wr,
                         input logic [7:0] wd, input logic [7:0] md,
                         input logic [5:0] en, input logic [5:0] ev);
        logic [7:0] exp_rd;
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; mode_bits = md; src_en = en;
        {ev_disconnect, ev_phase_mm, ev_parity, ev_bus_reset, ev_eop, ev_select} = ev;
        #1;
        exp_rd = (rd && (a == 3'd5 || a == 3'd7)) ? m_status() : 8'h00;
        check(tag, "rdata", bus_rdata, exp_rd);
        model_step(a, rd, wr, md, en, ev);
        @(negedge clk);
        check(tag, "irq", irq, m_irq);
        check(tag, "starts", {start_send, start_tgt_rx, start_ini_rx}, m_pulse);
    endtask

    task automatic read_status(input string tag, input logic [7:0] md, input logic [7:0] exp);
        bus_addr = 3'd5; bus_rd = 1; bus_wr = 0; mode_bits = md;
        {ev_disconnect, ev_phase_mm, ev_parity, ev_bus_reset, ev_eop, ev_select} = '0;
        #1;
        check(tag, "status", bus_rdata, exp);
        check(tag, "model", bus_rdata, m_status());
        model_step(3'd5, 1, 0, md, src_en, '0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1", "irq", irq, 0);
        check("R1", "starts", {start_send, start_tgt_rx, start_ini_rx}, 0);
        read_status("R1", M_NONE, 8'h00);

        // R2 send start, two different data values
        apply("R2", 3'd5, 0, 1, 8'hAA, M_DMA, 6'h3F, '0);
        check("R2", "pulse", start_send, 1);
        apply("R2", 3'd0, 0, 0, 8'h00, M_DMA, 6'h3F, '0);
        check("R2", "pulse_end", start_send, 0);
        read_status("R6", M_DMA, 8'h01);
        apply("R6", 3'd0, 0, 0, 8'h00, M_DMA, 6'h00, 6'b000010);   // eop ends transfer
        read_status("R7", M_DMA, 8'h80);
        apply("R9", 3'd7, 1, 0, 8'h00, M_DMA, 6'h00, '0);
        apply("R2", 3'd5, 0, 1, 8'h55, M_DMA, 6'h00, '0);
        check("R2", "pulse_data", start_send, 1);
        apply("R6", 3'd0, 0, 0, 8'h00, M_DMA, 6'h00, 6'b000010);
        apply("R9", 3'd7, 1, 0, 8'h00, M_DMA, 6'h00, '0);

        // R5 rejected starts
        apply("R5", 3'd5, 0, 1, 8'hFF, M_NONE, 6'h3F, '0);
        apply("R5", 3'd6, 0, 1, 8'hFF, M_DMA, 6'h3F, '0);
        apply("R5", 3'd7, 0, 1, 8'hFF, M_TGT, 6'h3F, '0);
        read_status("R5", M_DMA, 8'h00);

        // R3 target receive, then R5 busy reject, R6 bus reset abort
        apply("R3", 3'd6, 0, 1, 8'h12, M_TGT, 6'h00, '0);
        check("R3", "pulse", start_tgt_rx, 1);
        apply("R5", 3'd5, 0, 1, 8'h00, M_TGT, 6'h00, '0);
        check("R5", "busy_reject", start_send, 0);
        read_status("R6", M_TGT, 8'h01);
        apply("R6", 3'd0, 0, 0, 8'h00, M_TGT, 6'h00, 6'b000100);
        read_status("R6", M_TGT, 8'h02);
        apply("R9", 3'd7, 1, 0, 8'h00, M_TGT, 6'h00, '0);

        // R4 initiator receive, R6 abort by mode drop
        apply("R4", 3'd7, 0, 1, 8'h34, M_DMA, 6'h00, '0);
        check("R4", "pulse", start_ini_rx, 1);
        apply("R6", 3'd0, 0, 0, 8'h00, M_NONE, 6'h00, '0);
        read_status("R6", M_NONE, 8'h00);

        // R7 eop while idle ignored, then each source
        apply("R7", 3'd0, 0, 0, 8'h00, M_NONE, 6'h3F, 6'b000010);
        read_status("R7", M_NONE, 8'h00);
        apply("R7", 3'd0, 0, 0, 8'h00, M_NONE, 6'h3F, 6'b000001);
        read_status("R7", M_NONE, 8'h50);
        apply("R7", 3'd0, 0, 0, 8'h00, M_NONE, 6'h3F, 6'b111000);
        read_status("R7", M_NONE, 8'h7C);
        read_status("R9", M_NONE, 8'h7C);                    // address 5 read: nothing cleared
        apply("R9", 3'd7, 1, 0, 8'h00, M_NONE, 6'h3F, '0);
        check("R9", "irq_cleared", irq, 0);
        read_status("R9", M_NONE, 8'h00);

        // R8 masked source: flag only
        apply("R8", 3'd0, 0, 0, 8'h00, M_NONE, 6'b110111, 6'b001000);
        check("R8", "masked_irq", irq, 0);
        read_status("R8", M_NONE, 8'h20);
        apply("R8", 3'd0, 0, 0, 8'h00, M_NONE, 6'b010000, 6'b010000);
        check("R8", "enabled_irq", irq, 1);

        // R10 event during clearing read
        apply("R10", 3'd7, 1, 0, 8'h00, M_NONE, 6'h3F, 6'b001000);
        read_status("R10", M_NONE, 8'h30);
        apply("R11", 3'd3, 1, 0, 8'h00, M_NONE, 6'h3F, '0);     // other address reads 0
        apply("R9", 3'd7, 1, 0, 8'h00, M_NONE, 6'h3F, '0);

        // random phase: all requirements against the model
        for (int i = 0; i < 400; i++) begin
            logic [5:0] ev;
            logic [7:0] md;
            ev = '0;
            for (int k = 0; k < 6; k++) ev[k] = ($urandom_range(0, 9) == 0);
            md = $urandom_range(0, 3) == 0 ? 8'($urandom) : (($urandom_range(0, 1) != 0) ? M_TGT : M_DMA);
            apply("R11", 3'($urandom_range(4, 7)), ($urandom_range(0, 2) == 0),
                  ($urandom_range(0, 2) == 0), 8'($urandom), md, 6'($urandom), ev);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule